// File: doc/BRIEF.md
# Delayed-Sample Self-Correcting Pipeline Register

This block is a multi-bit pipeline register that protects its contents against short transients on its data input and against single upsets in its storage. Every data bit has two storage elements: a main flop that captures the input at the start of each slow cycle, and a shadow flop that captures the same input a fixed number of fast-clock phases later. The timing is modelled synchronously. One fast clock drives the block, a slow cycle is `PHASES` fast cycles long, the main capture happens in phase 0 and the shadow capture in phase `DELTA`.

In the phase after the shadow capture, each bit compares its two copies. A bit whose copies differ raises its local error. Any local error raises the register-wide error, which reloads every main bit from its shadow copy before the next main capture. The same error starts a stall output that holds downstream registers for exactly one slow cycle, and it advances a saturating error-event counter. Two fault-injection inputs flip stored bits, so that upsets in either copy can be provoked from outside the block.

Top module: `shadow_fix_reg`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `q`, `err_bits`, `err_any`, `stall` and `err_count` are all zero.
- R2: The phase counter is 0 on the first edge after reset and then counts 0..PHASES-1 cyclically. `q` takes `d_in` on each phase-0 edge. Changes of `d_in` at any other phase do not alter `q` unless a correction occurs.
- R3: The shadow copy takes `d_in` on the phase-`DELTA` edge, where 1 <= DELTA <= PHASES-2. If `d_in` differs at phase 0 and at phase `DELTA` (a transient shorter than `DELTA`), then after the check edge at phase DELTA+1, `q` equals the phase-`DELTA` value.
- R4: On each check edge, `err_bits` is loaded with the bitwise XOR of the main and shadow copies (bit i set means bit i mismatched). `err_any` is loaded with the OR of those bits. Both hold until the next check edge.
- R5: A transient that lasts through both the phase-0 and the phase-`DELTA` samples corrupts both copies and is not detected. `err_bits` is then 0, `err_any` is 0, and `q` keeps the corrupted value.
- R6: A flip injected into the main copy through `seu_main` (bit i set flips main bit i on that edge) is corrected at the next check edge. `q` returns to the shadow value.
- R7: A flip injected into the shadow copy through `seu_shadow` (bit i set flips shadow bit i as it is written or held) raises an error. It also reloads the main copy with the flipped shadow value, which is a false correction.
- R8: Each check edge with an error raises `stall` for exactly PHASES fast cycles, starting at that edge. An error at the following check edge keeps `stall` high for a further PHASES cycles.
- R9: `err_count` increases by one on each check edge with an error and saturates at 2^CNT_W-1. At any other edge it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | W | Combinational data feeding both copies |
| seu_main | input | W | Fault injection: flips main-copy bits |
| seu_shadow | input | W | Fault injection: flips shadow-copy bits |
| q | output | W | Main-copy register value |
| err_bits | output | W | Per-bit mismatch from the last check |
| err_any | output | 1 | OR of the last check's mismatches |
| stall | output | 1 | Downstream hold, one slow cycle per error |
| err_count | output | CNT_W | Saturating count of error events |

## Verification
In the error-counting function, correction and saturation can fall on the same check edge. In the stall function, a new error can fall on the very edge at which the previous stall window would close. Both cases are provoked by a long run of slow cycles that mismatch back to back: a sweep over every 8-bit transient pattern, followed by single-bit upsets in each copy. This pushes the counter past 255 events while errors arrive in consecutive slot pairs. For every slot the bench computes the restored value, the mismatch mask, the stall level mid-slot and at the check edge, and the saturated count. It judges them at the check edge and again mid-way through the next slot.

// File: rtl/shfx_pkg.sv
package shfx_pkg;

    // Timing strobes derived from the fast phase counter.
    typedef struct packed {
        logic cap;   // main capture phase
        logic shd;   // shadow capture phase
        logic chk;   // compare / restore phase
    } phase_strb_t;

    // Width able to hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/shfx_phase_gen.sv
module shfx_phase_gen
    import shfx_pkg::*;
#(
    parameter int unsigned PHASES = 4,
    parameter int unsigned DELTA  = 2
) (
    input  logic        clk,
    input  logic        rst,
    output phase_strb_t strb
);
    localparam int unsigned PW = cnt_width(PHASES - 1);
    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);
    localparam logic [PW-1:0] SHD_PH  = PW'(DELTA);
    localparam logic [PW-1:0] CHK_PH  = PW'(DELTA + 1);

    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (ph == LAST_PH) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    always_comb begin
        strb.cap = (ph == '0);
        strb.shd = (ph == SHD_PH);
        strb.chk = (ph == CHK_PH);
    end
endmodule

// File: rtl/shfx_cell_bank.sv
module shfx_cell_bank
    import shfx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_strb_t  strb,
    input  logic         restore,
    input  logic [W-1:0] d,
    input  logic [W-1:0] seu_m,
    input  logic [W-1:0] seu_s,
    output logic [W-1:0] main_q,
    output logic [W-1:0] shad_q,
    output logic [W-1:0] lerr
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic m_r;
        logic s_r;
        logic m_src;

        // Per-bit source select for the main element.
        always_comb begin
            if (strb.cap) begin
                m_src = d[i];
            end else if (strb.chk && restore) begin
                m_src = s_r;
            end else begin
                m_src = m_r;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                m_r <= 1'b0;
                s_r <= 1'b0;
            end else begin
                m_r <= m_src ^ seu_m[i];
                s_r <= (strb.shd ? d[i] : s_r) ^ seu_s[i];
            end
        end

        assign main_q[i] = m_r;
        assign shad_q[i] = s_r;
        assign lerr[i]   = m_r ^ s_r;
    end
endmodule

// File: rtl/shfx_err_unit.sv
module shfx_err_unit
    import shfx_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned PHASES = 4,
    parameter int unsigned CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk,
    input  logic [W-1:0]     lerr,
    output logic             restore,
    output logic [W-1:0]     err_bits,
    output logic             err_any,
    output logic             stall,
    output logic [CNT_W-1:0] err_count
);
    localparam int unsigned SW = cnt_width(PHASES);
    localparam logic [SW-1:0] STALL_LEN = SW'(PHASES);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic          any_mis;
    logic          evt;
    logic [SW-1:0] stall_cnt;

    assign any_mis = |lerr;
    assign evt     = chk && any_mis;
    assign restore = any_mis;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_bits <= '0;
            err_any  <= 1'b0;
        end else if (chk) begin
            err_bits <= lerr;
            err_any  <= any_mis;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_cnt <= '0;
        end else if (evt) begin
            stall_cnt <= STALL_LEN;
        end else if (stall_cnt != '0) begin
            stall_cnt <= stall_cnt - 1'b1;
        end
    end

    assign stall = (stall_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_count <= '0;
        end else if (evt && (err_count != CNT_MAX)) begin
            err_count <= err_count + 1'b1;
        end
    end
endmodule

// File: rtl/shadow_fix_reg.sv
module shadow_fix_reg
    import shfx_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned PHASES = 4,
    parameter int unsigned DELTA  = 2,
    parameter int unsigned CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     d_in,
    input  logic [W-1:0]     seu_main,
    input  logic [W-1:0]     seu_shadow,
    output logic [W-1:0]     q,
    output logic [W-1:0]     err_bits,
    output logic             err_any,
    output logic             stall,
    output logic [CNT_W-1:0] err_count
);
    phase_strb_t  strb;
    logic [W-1:0] main_v;
    logic [W-1:0] shad_v;
    logic [W-1:0] lerr_v;
    logic         restore;

    shfx_phase_gen #(.PHASES(PHASES), .DELTA(DELTA)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .strb (strb)
    );

    shfx_cell_bank #(.W(W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .restore (restore),
        .d       (d_in),
        .seu_m   (seu_main),
        .seu_s   (seu_shadow),
        .main_q  (main_v),
        .shad_q  (shad_v),
        .lerr    (lerr_v)
    );

    shfx_err_unit #(.W(W), .PHASES(PHASES), .CNT_W(CNT_W)) u_err (
        .clk       (clk),
        .rst       (rst),
        .chk       (strb.chk),
        .lerr      (lerr_v),
        .restore   (restore),
        .err_bits  (err_bits),
        .err_any   (err_any),
        .stall     (stall),
        .err_count (err_count)
    );

    assign q = main_v;
endmodule

// File: rtl/shfx_chk.sv
module shfx_chk #(
    parameter int unsigned W      = 8,
    parameter int unsigned PHASES = 4,
    parameter int unsigned CNT_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cap,
    input logic             chk,
    input logic [W-1:0]     main_v,
    input logic [W-1:0]     shad_v,
    input logic [W-1:0]     seu_main,
    input logic [W-1:0]     q,
    input logic [W-1:0]     err_bits,
    input logic             err_any,
    input logic             stall,
    input logic [CNT_W-1:0] err_count
);
    logic mis_evt;
    int unsigned since;

    assign mis_evt = chk && (main_v != shad_v);

    // Edges since the last error event, saturating at PHASES.
    always_ff @(posedge clk) begin
        if (rst) begin
            since <= PHASES;
        end else if (mis_evt) begin
            since <= 0;
        end else if (since != PHASES) begin
            since <= since + 1;
        end
    end

    // R6: mismatch at the check edge reloads the main copy from the shadow
    assert_restore_R6: assert property (@(posedge clk) disable iff (rst)
        (mis_evt && seu_main == '0) |=> (q == $past(shad_v)));

    // R2: outside capture and restore, q does not move
    assert_q_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!cap && !mis_evt && seu_main == '0) |=> $stable(q));

    // R5: matching copies report no error
    assert_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (chk && main_v == shad_v) |=> (!err_any && err_bits == '0));

    // R4: reported mask equals the compared difference
    assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
        chk |=> (err_bits == ($past(main_v) ^ $past(shad_v))));

    // R8: stall high exactly within PHASES edges of an error event
    assert_stall_len_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> (since < PHASES));
    assert_stall_cover_R8: assert property (@(posedge clk) disable iff (rst)
        (since < PHASES) |-> stall);

    // R9: counter advances on an event until saturated, otherwise holds
    assert_cnt_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (mis_evt && err_count != {CNT_W{1'b1}}) |=> (err_count == $past(err_count) + 1'b1));
    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !mis_evt |=> $stable(err_count));
endmodule

bind shadow_fix_reg shfx_chk #(.W(W), .PHASES(PHASES), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cap       (strb.cap),
    .chk       (strb.chk),
    .main_v    (main_v),
    .shad_v    (shad_v),
    .seu_main  (seu_main),
    .q         (q),
    .err_bits  (err_bits),
    .err_any   (err_any),
    .stall     (stall),
    .err_count (err_count)
);

// File: tb/shadow_fix_reg_tb_top.sv
`timescale 1ns/1ps
module shadow_fix_reg_tb_top;
    localparam int W = 8;
    localparam int CNT_W = 8;
    localparam int CNT_MAX = 255;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] seu_main = '0;
    logic [W-1:0] seu_shadow = '0;
    logic [W-1:0] q;
    logic [W-1:0] err_bits;
    logic         err_any;
    logic         stall;
    logic [CNT_W-1:0] err_count;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    logic [W-1:0] prev_mis = '0;
    logic         prev_evt = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    shadow_fix_reg #(.W(W), .PHASES(4), .DELTA(2), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .d_in(d_in), .seu_main(seu_main),
        .seu_shadow(seu_shadow), .q(q), .err_bits(err_bits),
        .err_any(err_any), .stall(stall), .err_count(err_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One slow cycle; entered at a negedge just before the phase-0 edge.
    task automatic slot(input logic [W-1:0] a, input logic [W-1:0] x,
                        input logic [W-1:0] b, input logic [W-1:0] sm,
                        input logic [W-1:0] ss);
        logic [W-1:0] mv, sv, mm;
        logic ev;
        d_in = a;
        @(negedge clk);            // phase 0 edge done: main = a
        d_in = x; seu_main = sm;
        @(negedge clk);            // phase 1 edge done: main ^= sm
        seu_main = '0; d_in = b; seu_shadow = ss;
        @(negedge clk);            // phase 2 edge done: shadow = b ^ ss
        seu_shadow = '0; d_in = ~a;
        mv = a ^ sm;
        sv = b ^ ss;
        mm = mv ^ sv;
        ev = |mm;
        check("R2 q before check", 32'(q), 32'(mv));
        check("R8 stall mid-slot", 32'(stall), 32'(prev_evt));
        check("R4 err_bits held", 32'(err_bits), 32'(prev_mis));
        @(negedge clk);            // phase 3 check edge done
        if (ev && exp_cnt < CNT_MAX) exp_cnt++;
        check("R3/R5/R6/R7 q after check", 32'(q), 32'(ev ? sv : mv));
        check("R4 err_bits", 32'(err_bits), 32'(mm));
        check("R4 err_any", 32'(err_any), 32'(ev));
        check("R8 stall at check", 32'(stall), 32'(ev));
        check("R9 err_count", 32'(err_count), 32'(exp_cnt));
        prev_mis = mm;
        prev_evt = ev;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 q in reset", 32'(q), 0);
        check("R1 stall in reset", 32'(stall), 0);
        rst = 1'b0;
        check("R1 err_count", 32'(err_count), 0);
        check("R1 err_any", 32'(err_any), 0);
        check("R1 err_bits", 32'(err_bits), 0);

        // R2: clean slots, junk on non-capture phases
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] a = W'(k * 53 + 7);
            slot(a, ~a, a, '0, '0);
        end

        // R3: every short transient pattern k (phase-0 value off by k)
        for (int k = 0; k < 256; k++) begin
            logic [W-1:0] good = W'(k * 37 + 11);
            slot(good ^ W'(k), W'(k * 5), good, '0, '0);
        end

        // R5: long transients corrupt both samples, no detection
        for (int k = 1; k < 6; k++) begin
            logic [W-1:0] bad = W'(k * 71);
            slot(bad, ~bad, bad, '0, '0);
        end

        // R6: single main upsets per bit, back to back
        for (int i = 0; i < W; i++) begin
            slot(8'hA5, 8'h00, 8'hA5, W'(1) << i, '0);
        end

        // R7: single shadow upsets per bit (false correction)
        for (int i = 0; i < W; i++) begin
            slot(8'h3C, 8'hFF, 8'h3C, '0, W'(1) << i);
        end

        // R8: error followed by clean slot, stall must drop
        slot(8'h10, 8'h00, 8'h11, '0, '0);
        slot(8'h22, 8'h00, 8'h22, '0, '0);
        slot(8'h22, 8'h00, 8'h22, '0, '0);

        // R9: counter saturated after more than 255 events
        check("R9 saturated", 32'(err_count), CNT_MAX);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule